// File: doc/BRIEF.md
# Zero-Suppressing Level-1 Hit Pipeline

This block sits behind the time digitisers of a four-channel group. On every fourth clock edge it captures a snapshot of the four channels' hit words and valid flags into a hold-and-shift register. It then moves that snapshot, one channel per clock, to a zero-suppression stage that writes only the valid hits into an on-chip circular memory. The memory is split into blocks, and each block holds the hits of one coarse time period. Because each channel is visited once per four clocks, two hits on the same channel must be at least four clocks apart to be recorded separately.

A period-boundary strobe advances the write pointer to the next block, modulo the block count, and empties that block. When a trigger names a period index, the block streams out the stored words of that block and then those of the following one, giving a two-period window. A block that is still being filled is read only after it closes. Event formatting and truncation are handled downstream.

Top module: `zs_l1_pipe`

## Requirements
- R1: After reset the output valid is low, the write block is 0 and every block is empty, so reading a block never written yields no words.
- R2: All channel words and valid flags are sampled together on the first rising edge after reset and on every fourth edge after that. Input values at the edges in between have no effect.
- R3: The hits of one snapshot are stored in channel order 0, 1, 2, 3. The stage handles one channel slot per clock, so a slot's hit is written 1 to 4 edges after the snapshot.
- R4: A slot whose valid flag was low writes no word and leaves the block's word count unchanged.
- R5: A block keeps at most 16 words of 16 bits. A hit arriving at a full block is dropped, and the block keeps its first 16 words.
- R6: A period strobe sampled high advances the write block by one, modulo 16, and clears the new block's count. A hit written on that same edge goes into the block being closed.
- R7: A trigger with index b outputs the words of block b and then those of block (b+1) mod 16, each in stored order. Each word is shown for one cycle with the output valid high.
- R8: A block equal to the current write block is not read until a period strobe has closed it.
- R9: A trigger that arrives while a readout is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| hit_data | input | 64 | Channel hit words, channel n at bits [16n+15:16n] |
| hit_valid | input | 4 | Per-channel hit present flag, bit n for channel n |
| period_strobe | input | 1 | Coarse period boundary, one cycle |
| trig | input | 1 | Readout request |
| trig_blk | input | 4 | First period index of the two-period window |
| out_data | output | 16 | Stored hit word |
| out_valid | output | 1 | out_data holds a word this cycle |

## Verification
On every cycle, the assertions check that the block count never exceeds its capacity, that an empty slot leaves the count unchanged, that a strobe steps the write block and leaves the new block empty, and that the block being read is never the open one. Only the bench's scenarios can show the actual content and order of the words that come out. This covers the sparse sampling of inputs every four edges, dropping hits at a full block, the wrap from block 15 to block 0, holding back a read until its open block closes, and ignoring a trigger during a busy readout.

// File: rtl/zs_l1_pipe.sv
module zs_l1_pipe #(
  parameter int NCH       = 4,
  parameter int WORD_W    = 16,
  parameter int NBLK      = 16,
  parameter int BLK_DEPTH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH*WORD_W-1:0] hit_data,
  input  logic [NCH-1:0]        hit_valid,
  input  logic                  period_strobe,
  input  logic                  trig,
  input  logic [$clog2(NBLK)-1:0] trig_blk,
  output logic [WORD_W-1:0]     out_data,
  output logic                  out_valid
);
  localparam int BW = $clog2(NBLK);
  localparam int IW = $clog2(BLK_DEPTH);
  localparam int CW = IW + 1;
  localparam int PW = $clog2(NCH);
  localparam logic [CW-1:0] FULL = CW'(BLK_DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_READ} rd_st_t;

  logic [PW-1:0]     phase;
  logic [WORD_W-1:0] hold_d [NCH];
  logic [NCH-1:0]    hold_v;
  logic [BW-1:0]     wblk;
  logic [CW-1:0]     cnt [NBLK];
  logic [WORD_W-1:0] mem [NBLK*BLK_DEPTH];
  logic [CW-1:0]     cur_cnt;
  logic              wr_en;

  rd_st_t        st;
  logic [BW-1:0] rblk;
  logic [IW-1:0] ridx;
  logic          second;
  logic [CW-1:0] rcnt;
  logic          rlast;

  assign cur_cnt = cnt[wblk];
  assign wr_en   = hold_v[0] && (cur_cnt != FULL);
  assign rcnt    = cnt[rblk];
  assign rlast   = ({1'b0, ridx} + 1'b1) == rcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= '0;
      hold_v <= '0;
      for (int i = 0; i < NCH; i++) hold_d[i] <= '0;
    end else begin
      phase <= phase + 1'b1;
      if (phase == '0) begin
        hold_v <= hit_valid;
        for (int i = 0; i < NCH; i++) hold_d[i] <= hit_data[i*WORD_W +: WORD_W];
      end else begin
        hold_v <= hold_v >> 1;
        for (int i = 0; i < NCH - 1; i++) hold_d[i] <= hold_d[i+1];
        hold_d[NCH-1] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wblk <= '0;
      for (int b = 0; b < NBLK; b++) cnt[b] <= '0;
    end else begin
      if (wr_en) cnt[wblk] <= cur_cnt + 1'b1;
      if (period_strobe) begin
        wblk <= wblk + 1'b1;
        cnt[BW'(wblk + 1'b1)] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wblk, cur_cnt[IW-1:0]}] <= hold_d[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rblk      <= '0;
      ridx      <= '0;
      second    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      case (st)
        S_IDLE: if (trig) begin
          rblk   <= trig_blk;
          second <= 1'b0;
          st     <= S_WAIT;
        end
        S_WAIT: if (rblk != wblk) begin
          ridx <= '0;
          if (rcnt != '0) st <= S_READ;
          else if (!second) begin
            second <= 1'b1;
            rblk   <= rblk + 1'b1;
          end else st <= S_IDLE;
        end
        S_READ: begin
          out_valid <= 1'b1;
          out_data  <= mem[{rblk, ridx}];
          if (rlast) begin
            if (!second) begin
              second <= 1'b1;
              rblk   <= rblk + 1'b1;
              st     <= S_WAIT;
            end else st <= S_IDLE;
          end else ridx <= ridx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cur_cnt <= FULL); // R5
  AST_EMPTY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_v[0] && !period_strobe) |=> (cur_cnt == $past(cur_cnt))); // R4
  AST_STROBE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    period_strobe |=> (wblk == BW'($past(wblk) + 1'b1))); // R6
  AST_STROBE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    period_strobe |=> (cur_cnt == '0)); // R6
  AST_NO_OPEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ) |-> (rblk != wblk)); // R8
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $past(st) == S_IDLE) |-> !out_valid); // R7
endmodule

// File: tb/tb_zs_l1_pipe.sv
module tb_zs_l1_pipe;
  localparam int PER = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] hit_data = '0;
  logic [3:0]  hit_valid = '0;
  logic        period_strobe = 1'b0;
  logic        trig = 1'b0;
  logic [3:0]  trig_blk = '0;
  logic [15:0] out_data;
  logic        out_valid;

  int checks = 0;
  int errors = 0;

  zs_l1_pipe dut (
    .clk(clk), .rst_n(rst_n), .hit_data(hit_data), .hit_valid(hit_valid),
    .period_strobe(period_strobe), .trig(trig), .trig_blk(trig_blk),
    .out_data(out_data), .out_valid(out_valid)
  );

  always #10 clk = ~clk;

  logic [15:0] blk [16][$];
  logic [15:0] got [$];
  logic [15:0] fr_d [4];
  logic        fr_v [4];
  int          e = 0;
  int          wb = 0;
  int          pc = 0;
  bit          auto_str = 1'b0;
  int          hit_pct = 0;

  function automatic void put(int ch);
    if (fr_v[ch] && blk[wb].size() < 16) blk[wb].push_back(fr_d[ch]);
  endfunction

  function automatic void model_edge(bit s);
    int j;
    j = e % 4;
    if (j == 0) begin
      if (e > 0) put(3);
      for (int c = 0; c < 4; c++) begin
        fr_d[c] = hit_data[c*16 +: 16];
        fr_v[c] = hit_valid[c];
      end
    end else put(j - 1);
    if (s) begin
      wb = (wb + 1) % 16;
      blk[wb].delete();
    end
    e++;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit trg, logic [3:0] tb, bit force_str);
    bit s;
    s = force_str || (auto_str && pc == PER - 1);
    for (int c = 0; c < 4; c++) begin
      hit_valid[c] = (($urandom % 100) < hit_pct);
      hit_data[c*16 +: 16] = 16'($urandom);
    end
    period_strobe = s;
    trig = trg;
    trig_blk = tb;
    @(posedge clk);
    model_edge(s);
    pc = s ? 0 : pc + 1;
    @(negedge clk);
    if (out_valid) got.push_back(out_data);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'd0, 1'b0);
  endtask

  task automatic cmp_q(logic [15:0] exp [$], string req);
    check(got.size() == exp.size(), req, "word count", got.size(), exp.size());
    if (got.size() == exp.size())
      for (int i = 0; i < exp.size(); i++)
        check(got[i] === exp[i], req, $sformatf("word %0d", i), got[i], exp[i]);
    got.delete();
  endtask

  task automatic check_read(int b, string req);
    logic [15:0] exp [$];
    exp = blk[b];
    foreach (blk[(b + 1) % 16][i]) exp.push_back(blk[(b + 1) % 16][i]);
    cmp_q(exp, req);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;

    // R1: never-written blocks 5 and 6 read as empty
    step(1'b1, 4'd5, 1'b0);
    idle(20);
    check_read(5, "R1");

    // R5: 24 hits into block 0, only the first 16 kept
    hit_pct = 100;
    idle(24);
    hit_pct = 0;
    idle(4);
    step(1'b0, 4'd0, 1'b1);
    check(blk[0].size() == 16, "R5", "model block fill", blk[0].size(), 16);
    // R8: block 1 is open; only block 0 comes out until it closes
    step(1'b1, 4'd0, 1'b0);
    hit_pct = 50;
    idle(30);
    step(1'b1, 4'd0, 1'b0); // R9: ignored while waiting on block 1
    idle(30);
    hit_pct = 0;
    idle(4);
    begin
      logic [15:0] b0 [$];
      b0 = blk[0];
      cmp_q(b0, "R8");
    end
    step(1'b0, 4'd0, 1'b1);
    idle(40);
    begin
      logic [15:0] b1 [$];
      b1 = blk[1];
      cmp_q(b1, "R9");
    end

    // R6 / R7: wrap from block 15 to block 0
    hit_pct = 30;
    auto_str = 1'b1;
    pc = 0;
    while (wb != 1) idle(1);
    auto_str = 1'b0;
    step(1'b1, 4'd15, 1'b0);
    idle(50);
    check_read(15, "R7");

    // R2/R3/R4: random hits changing every cycle, random triggers
    auto_str = 1'b1;
    for (int it = 0; it < 30; it++) begin
      int b;
      hit_pct = 10 + ($urandom % 60);
      idle(20 + ($urandom % 80));
      b = (wb + 16 - 2 - ($urandom % 8)) % 16;
      step(1'b1, 4'(b), 1'b0);
      idle(60);
      check_read(b, "R2 R3 R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule